// File: doc/BRIEF.md
# Registered-or-Combinational Output Macrocell Array with Product-Term Feedback

This block is the logic core of a small sum-of-products device. A programmable AND array forms product terms from the primary inputs and from signals fed back by the outputs. Each output owns a fixed group of product terms that are ORed together. The resulting sum enters an output macrocell. There, a static path bit picks either the raw sum or a D flip-flop that samples the sum on every rising clock edge. A static enable bit then decides whether the selected value is driven onto the output pin.

The value picked by the path bit, and not the pin, goes back into the AND array as a new signal with a true rail and a complement rail. Because registered outputs return to the array, a clocked state machine can be built entirely inside the block. A combinational output feeds back only into the terms of higher-numbered outputs. Terms of its own output and of lower-numbered outputs see its flip-flop instead, so the array never contains a combinational loop. All configuration inputs are static. A pin is modelled as a value plus a drive enable.

Top module: `pal_array`

## Requirements
- R1: A product term is the AND of every literal whose bit is set in that term's 16-bit mask, and a term with an empty mask is 0. Literal bit 2s is the true rail of signal s and bit 2s+1 is its complement. Signals 0 to 3 are `in_pins[0..3]`, and signals 4 to 7 are the feedbacks of outputs 0 to 3.
- R2: Output j's sum is the OR of terms 4j to 4j+3, and term t's mask sits at `and_cfg[16t +: 16]`. A term never influences another output's sum.
- R3: With `path_cfg[j]=1` (registered), the pin shows the sum sampled at the latest rising clock edge and holds it until the next edge, even while inputs change.
- R4: With `path_cfg[j]=0` (combinational), the pin follows the sum within the same cycle.
- R5: With `oe_cfg[j]=0`, `pin_en[j]` is 0 (high impedance) and `pin_q[j]` reads 0. With `oe_cfg[j]=1`, `pin_en[j]` is 1.
- R6: The feedback of output j is the path-selected value whatever the state of `oe_cfg[j]`. When the pin is enabled, it equals that value.
- R7: A synchronous active-high `rst` clears every macrocell flip-flop to 0 at the next rising edge, both at start-up and mid-run.
- R8: Registered outputs whose terms use their own feedback form a working state machine. For example, a 2-bit binary counter steps 00, 01, 10, 11 and wraps to 00.
- R9: The complement rail of a feedback signal is usable, for example an output equal to the inverse of another output's register.
- R10: A combinational output's live sum reaches only the terms of higher-numbered outputs. Terms of the same or lower-numbered outputs receive that output's flip-flop value, which is the sum sampled at the last edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flip-flops sample on the rising edge |
| rst | input | 1 | Synchronous active-high clear of all macrocell flip-flops |
| in_pins | input | 4 | Primary input signals 0 to 3 |
| and_cfg | input | 256 | AND-array masks, 16 bits per term, 16 terms |
| path_cfg | input | 4 | Per-output path: 1 registered, 0 combinational |
| oe_cfg | input | 4 | Per-output pin drive enable |
| pin_q | output | 4 | Pin values (0 when the pin is not driven) |
| pin_en | output | 4 | Pin drive enables (0 means high impedance) |

## Verification
The hardest case to reach from the ports is feedback that the pins cannot show. For R6, the value leaving a disabled output is invisible at its own pin. The stimulus therefore routes that output's feedback into a second, enabled output, so the hidden register becomes visible there. The same approach exposes the layering of R10: a combinational output drives both a higher and a lower output at once, and the two pins differ for one cycle, showing the live sum on one and the sampled sum on the other. Hold behaviour (R3) is reached by changing inputs between edges and checking that the registered pin does not move until the next edge.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic {
        PATH_COMB = 1'b0,
        PATH_REG  = 1'b1
    } path_e;

endpackage

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
    parameter int N_SIG = 8,
    parameter int N_PT  = 4,
    localparam int LIT_W = 2 * N_SIG
) (
    input  logic [LIT_W-1:0]      lits,
    input  logic [N_PT*LIT_W-1:0] masks,
    output logic [N_PT-1:0]       terms
);

    for (genvar t = 0; t < N_PT; t++) begin : gen_term
        logic [LIT_W-1:0] mask;
        assign mask     = masks[t*LIT_W +: LIT_W];
        // An empty mask yields 0 so unused terms do not disturb the OR
        assign terms[t] = (|mask) && ((lits & mask) == mask);
    end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sum,
    input  path_e path_sel,
    input  logic  oe,
    output logic  reg_q,
    output logic  fb,
    output logic  pin_q,
    output logic  pin_en
);

    logic q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= 1'b0;
        end else begin
            q_r <= sum;
        end
    end

    always_comb begin
        unique case (path_sel)
            PATH_REG:  fb = q_r;
            PATH_COMB: fb = sum;
            default:   fb = sum;
        endcase
    end

    assign reg_q  = q_r;
    assign pin_en = oe;
    assign pin_q  = oe & fb;

endmodule

// File: rtl/pal_array.sv
module pal_array
    import pal_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int N_PT  = 4,
    localparam int N_SIG      = N_IN + N_OUT,
    localparam int LIT_W      = 2 * N_SIG,
    localparam int TERM_CFG_W = N_PT * LIT_W,
    localparam int CFG_W      = N_OUT * TERM_CFG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  in_pins,
    input  logic [CFG_W-1:0] and_cfg,
    input  logic [N_OUT-1:0] path_cfg,
    input  logic [N_OUT-1:0] oe_cfg,
    output logic [N_OUT-1:0] pin_q,
    output logic [N_OUT-1:0] pin_en
);

    logic [N_OUT-1:0] reg_vec;
    logic [N_OUT-1:0] fb_vec;
    logic [N_OUT-1:0] sum_vec;

    for (genvar j = 0; j < N_OUT; j++) begin : gen_out
        logic [N_OUT-1:0] fb_src;
        logic [LIT_W-1:0] lits;
        logic [N_PT-1:0]  terms;
        logic             sum_l;
        logic             fb_l;
        logic             q_l;
        logic             pq_l;
        logic             pe_l;

        // Live feedback only from lower outputs; otherwise the register
        for (genvar k = 0; k < N_OUT; k++) begin : gen_fb
            if (k < j) begin : g_live
                assign fb_src[k] = gen_out[k].fb_l;
            end else begin : g_reg
                assign fb_src[k] = reg_vec[k];
            end
        end

        for (genvar s = 0; s < N_IN; s++) begin : gen_in_lit
            assign lits[2*s]     = in_pins[s];
            assign lits[2*s + 1] = ~in_pins[s];
        end

        for (genvar k = 0; k < N_OUT; k++) begin : gen_fb_lit
            assign lits[2*(N_IN + k)]     = fb_src[k];
            assign lits[2*(N_IN + k) + 1] = ~fb_src[k];
        end

        pal_and_plane #(
            .N_SIG (N_SIG),
            .N_PT  (N_PT)
        ) u_plane (
            .lits  (lits),
            .masks (and_cfg[j*TERM_CFG_W +: TERM_CFG_W]),
            .terms (terms)
        );

        assign sum_l = |terms;

        pal_macrocell u_mc (
            .clk      (clk),
            .rst      (rst),
            .sum      (sum_l),
            .path_sel (path_e'(path_cfg[j])),
            .oe       (oe_cfg[j]),
            .reg_q    (q_l),
            .fb       (fb_l),
            .pin_q    (pq_l),
            .pin_en   (pe_l)
        );

        assign reg_vec[j] = q_l;
        assign fb_vec[j]  = fb_l;
        assign sum_vec[j] = sum_l;
        assign pin_q[j]   = pq_l;
        assign pin_en[j]  = pe_l;
    end

endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
    parameter int N_OUT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_OUT-1:0] path_cfg,
    input logic [N_OUT-1:0] oe_cfg,
    input logic [N_OUT-1:0] pin_q,
    input logic [N_OUT-1:0] pin_en,
    input logic [N_OUT-1:0] sum_vec,
    input logic [N_OUT-1:0] fb_vec,
    input logic [N_OUT-1:0] reg_vec
);

    for (genvar j = 0; j < N_OUT; j++) begin : gen_chk
        assert_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (reg_vec[j] == 1'b0));

        assert_capture_sum_R3: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (reg_vec[j] == $past(sum_vec[j])));

        assert_comb_path_R4: assert property (@(posedge clk) disable iff (rst)
            !path_cfg[j] |-> (fb_vec[j] == sum_vec[j]));

        assert_reg_path_R3: assert property (@(posedge clk) disable iff (rst)
            path_cfg[j] |-> (fb_vec[j] == reg_vec[j]));

        assert_pin_off_R5: assert property (@(posedge clk) disable iff (rst)
            !oe_cfg[j] |-> (!pin_en[j] && !pin_q[j]));

        assert_pin_tracks_fb_R6: assert property (@(posedge clk) disable iff (rst)
            oe_cfg[j] |-> (pin_en[j] && (pin_q[j] == fb_vec[j])));
    end

endmodule

bind pal_array pal_array_chk #(.N_OUT(N_OUT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .path_cfg (path_cfg),
    .oe_cfg   (oe_cfg),
    .pin_q    (pin_q),
    .pin_en   (pin_en),
    .sum_vec  (sum_vec),
    .fb_vec   (fb_vec),
    .reg_vec  (reg_vec)
);

// File: tb/pal_array_bench.sv
module pal_array_bench;

    localparam int N_IN  = 4;
    localparam int N_OUT = 4;
    localparam int N_PT  = 4;
    localparam int LIT_W = 2 * (N_IN + N_OUT);
    localparam int CFG_W = N_OUT * N_PT * LIT_W;

    logic             clk = 1'b0;
    logic             rst;
    logic [N_IN-1:0]  in_pins;
    logic [CFG_W-1:0] and_cfg;
    logic [N_OUT-1:0] path_cfg;
    logic [N_OUT-1:0] oe_cfg;
    logic [N_OUT-1:0] pin_q;
    logic [N_OUT-1:0] pin_en;

    always #5 clk = ~clk;

    pal_array #(.N_IN(N_IN), .N_OUT(N_OUT), .N_PT(N_PT)) u_pal_array (
        .clk      (clk),
        .rst      (rst),
        .in_pins  (in_pins),
        .and_cfg  (and_cfg),
        .path_cfg (path_cfg),
        .oe_cfg   (oe_cfg),
        .pin_q    (pin_q),
        .pin_en   (pin_en)
    );

    typedef struct packed {
        logic [N_OUT-1:0] mask;
        logic [N_OUT-1:0] q;
        logic [N_OUT-1:0] en;
    } exp_t;

    exp_t  exp_fifo[$];
    string tag_fifo[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    function automatic int lit(input int sig, input int inv);
        return 2 * sig + inv;
    endfunction

    task automatic add_lit(input int term, input int l);
        and_cfg[term*LIT_W + l] = 1'b1;
    endtask

    // Driver: apply inputs after an edge, queue what the pins must show at the following falling edge
    task automatic step(input logic [N_IN-1:0] iv, input string tag,
                        input logic [N_OUT-1:0] m, input logic [N_OUT-1:0] q,
                        input logic [N_OUT-1:0] en);
        @(posedge clk);
        #1;
        in_pins = iv;
        if (m != '0) begin
            exp_fifo.push_back('{mask: m, q: q, en: en});
            tag_fifo.push_back(tag);
        end
        @(negedge clk);
        #1;
    endtask

    // Monitor: compare queued expectations at the falling edge
    always @(negedge clk) begin
        while (exp_fifo.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_fifo.pop_front();
            t = tag_fifo.pop_front();
            checks++;
            if ((((pin_q ^ e.q) & e.mask) != '0) || (((pin_en ^ e.en) & e.mask) != '0)) begin
                fails++;
                $display("FAIL %s: pin_q=%b pin_en=%b expected pin_q=%b pin_en=%b (mask %b)",
                         t, pin_q, pin_en, e.q, e.en, e.mask);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        in_pins  = '0;
        and_cfg  = '0;
        path_cfg = 4'b1111;
        oe_cfg   = 4'b1111;
        add_lit(0, lit(0, 0));
        @(negedge clk);
        #1;

        // R7: reset clears the flip-flop even with its sum high
        step(4'b0001, "", 4'b0000, 4'b0000, 4'b0000);
        step(4'b0001, "R7 start-up clear", 4'b0001, 4'b0000, 4'b1111);
        rst = 1'b0;
        step(4'b0001, "R3 first capture", 4'b0001, 4'b0001, 4'b1111);

        // R1/R2/R4: combinational sums of several term groups
        and_cfg  = '0;
        path_cfg = 4'b0000;
        add_lit(0, lit(0, 0)); add_lit(0, lit(1, 0));
        add_lit(1, lit(2, 1)); add_lit(1, lit(3, 0));
        add_lit(5, lit(2, 0));
        add_lit(11, lit(1, 0)); add_lit(11, lit(3, 1));
        step(4'b0011, "R1 and of literals", 4'b1111, 4'b0101, 4'b1111);
        step(4'b1000, "R2 second term of out0", 4'b1111, 4'b0001, 4'b1111);
        step(4'b0100, "R2 term isolation", 4'b1111, 4'b0010, 4'b1111);
        step(4'b0111, "R4 same-cycle follow", 4'b1111, 4'b0111, 4'b1111);
        step(4'b0000, "R1 empty mask is zero", 4'b1111, 4'b0000, 4'b1111);

        // R3: registered output holds between edges
        and_cfg  = '0;
        path_cfg = 4'b0001;
        add_lit(0, lit(0, 0));
        step(4'b0001, "R3 hold before edge", 4'b0001, 4'b0000, 4'b1111);
        step(4'b0000, "R3 capture at edge", 4'b0001, 4'b0001, 4'b1111);
        step(4'b0000, "R3 capture low", 4'b0001, 4'b0000, 4'b1111);

        // R5/R6: disabled pin, feedback seen through out1
        oe_cfg = 4'b1110;
        add_lit(4, lit(4, 0));
        step(4'b0001, "R5 pin off", 4'b0011, 4'b0000, 4'b1110);
        step(4'b0001, "R6 feedback with pin off", 4'b0011, 4'b0010, 4'b1110);

        // R9: complement rail of a feedback
        oe_cfg  = 4'b1111;
        and_cfg = '0;
        add_lit(0, lit(0, 0));
        add_lit(4, lit(4, 1));
        step(4'b0000, "R9 complement of high", 4'b0011, 4'b0001, 4'b1111);
        step(4'b0000, "R9 complement of low", 4'b0011, 4'b0010, 4'b1111);

        // R8: 2-bit counter from registered feedback
        and_cfg  = '0;
        path_cfg = 4'b0011;
        add_lit(0, lit(4, 1));
        add_lit(4, lit(5, 0)); add_lit(4, lit(4, 1));
        add_lit(5, lit(5, 1)); add_lit(5, lit(4, 0));
        rst = 1'b1;
        step(4'b0000, "R7 clear before count", 4'b0011, 4'b0000, 4'b1111);
        rst = 1'b0;
        step(4'b0000, "R8 count 01", 4'b0011, 4'b0001, 4'b1111);
        step(4'b0000, "R8 count 10", 4'b0011, 4'b0010, 4'b1111);
        step(4'b0000, "R8 count 11", 4'b0011, 4'b0011, 4'b1111);
        step(4'b0000, "R8 count wrap", 4'b0011, 4'b0000, 4'b1111);
        step(4'b0000, "R8 count 01 again", 4'b0011, 4'b0001, 4'b1111);
        rst = 1'b1;
        step(4'b0000, "R7 mid-run clear", 4'b0011, 4'b0000, 4'b1111);
        rst = 1'b0;

        // R10: live feedback upward, registered feedback downward
        and_cfg  = '0;
        path_cfg = 4'b0000;
        add_lit(4, lit(0, 0));
        add_lit(0, lit(5, 0));
        add_lit(8, lit(5, 0));
        step(4'b0001, "R10 live up, sampled down", 4'b0111, 4'b0110, 4'b1111);
        step(4'b0000, "R10 sampled value arrives", 4'b0111, 4'b0001, 4'b1111);

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule